// File: doc/BRIEF.md
# Four-Channel Fixed-Priority DMA Controller

This block lets up to four peripherals move data to or from memory without the processor touching each byte. Software first programs each channel's start address, its transfer count and its transfer kind through a byte-wide write port, then sets the channel enable bits. When an enabled channel raises its request line, the controller asks the processor for the bus with a hold request. Only after the processor answers with hold acknowledge does the controller drive the bus. It then serves the highest-priority pending channel one transfer at a time.

Each transfer takes an address phase and then a strobe phase. In the address phase the address strobe pulses, the channel's address is on the bus and the channel's acknowledge line is low. In the strobe phase the memory and I/O strobes that match the transfer kind are asserted. The ready input can stretch the strobe phase. After each transfer the channel's address steps up by one and its count steps down by one. The last transfer of a block raises terminal count, and the channel then disables itself. A mark output flags every 128th transfer. The bus is handed back as soon as no enabled request remains at an arbitration point. Register writes arriving while hold request is high are dropped, so programming never collides with a running block.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hold_req, bus_en, addr_stb, term_cnt and mark_pulse are 0, dack_n and all four strobes are high, bus_addr is 0, and every channel is disabled, so active requests raise no hold request.
- R2: Register address 2k holds channel k's 16-bit address and 2k+1 holds its 16-bit control word. A shared byte toggle steers each write to the low byte first and then the high byte. A write to address 8 clears the toggle and loads channel enables from data bits [3:0]. Requests from disabled channels are ignored.
- R3: An enabled request raises hold_req on the next clock. bus_en and every dack_n line stay inactive until hold_ack has been seen high.
- R4: When several enabled channels request at once, the lowest-numbered one is served first.
- R5: Each transfer starts with one address-phase cycle in which addr_stb is 1, bus_addr equals the channel's current address and only that channel's dack_n bit is 0. Successive transfers of a channel use consecutive addresses.
- R6: Control word bits [15:14] select the kind. 10 is read (mem_rd_n and io_wr_n low), 01 is write (io_rd_n and mem_wr_n low), and 00 or 11 is verify (no strobe low). Strobes are only active in the strobe phase.
- R7: While ready is 0 in the strobe phase, the phase is held with the strobes and address unchanged.
- R8: A count field (bits [13:0]) of N yields N+1 transfers. term_cnt is 1 during the strobe phase of the last one, and the channel is disabled afterwards.
- R9: mark_pulse is 1 during the strobe phase of every transfer whose zero-based index since reset, counted over all channels, is 127 modulo 128, and is 0 otherwise.
- R10: When an arbitration point finds no enabled request, hold_req falls on the next clock.
- R11: Register writes made while hold_req is 1 change no register and do not move the byte toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| dreq | input | 4 | Peripheral request lines, bit 0 highest priority |
| hold_ack | input | 1 | Bus granted by processor |
| ready | input | 1 | Low inserts wait cycles in the strobe phase |
| hold_req | output | 1 | Bus request to processor |
| dack_n | output | 4 | Active-low per-channel acknowledge |
| bus_en | output | 1 | Controller is driving the bus |
| addr_stb | output | 1 | Address phase marker for the external latch |
| bus_addr | output | 16 | Transfer address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| term_cnt | output | 1 | Last transfer of a block |
| mark_pulse | output | 1 | Every 128th transfer |

## Verification
On every cycle the assertions check a set of local invariants. At most one acknowledge is active, and only under hold request. The grant never skips a lower pending channel. Strobes appear only in their legal read or write pairs, and a low ready freezes the strobe phase. Terminal count and mark fall only inside a serviced transfer, a terminal transfer leaves the channel disabled, and locked register writes change nothing. Only the directed scenarios can show the actual values: addresses and byte ordering, the number of transfers a count produces, which channel wins first, the exact cycle the bus is released, and the precise position of the mark among hundreds of transfers.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_ARB  = 3'd2,
    ST_ADDR = 3'd3,
    ST_STRB = 3'd4
  } dma_st_e;

  localparam logic [1:0] XK_VERIFY = 2'b00;
  localparam logic [1:0] XK_WRITE  = 2'b01;
  localparam logic [1:0] XK_READ   = 2'b10;

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14,
  parameter int DW  = 8,
  parameter int RAW = 4,
  parameter int CHW = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [RAW-1:0]           waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     lock_i,
  input  logic                     upd_i,
  input  logic [CHW-1:0]           upd_ch_i,
  output logic [NCH-1:0][AW-1:0]   addr_o,
  output logic [NCH-1:0][CW-1:0]   cnt_o,
  output logic [NCH-1:0][1:0]      typ_o,
  output logic [NCH-1:0]           en_o
);

  localparam int WW = 2 * DW;

  logic           wr_ok;
  logic           sel_mode;
  logic           sel_chan;
  logic           ff_q, ff_d;
  logic [NCH-1:0] en_q, en_d;

  assign wr_ok    = wr_i && !lock_i;
  assign sel_mode = (waddr_i == RAW'(2 * NCH));
  assign sel_chan = (waddr_i < RAW'(2 * NCH));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic          hit_a, hit_c, step;
    logic [AW-1:0] a_q, a_d;
    logic [WW-1:0] w_q, w_d;
    logic          a_ld, w_ld;

    assign hit_a = wr_ok && (waddr_i == RAW'(2 * k));
    assign hit_c = wr_ok && (waddr_i == RAW'(2 * k + 1));
    assign step  = upd_i && (upd_ch_i == CHW'(k));
    assign a_ld  = hit_a || step;
    assign w_ld  = hit_c || step;

    always_comb begin
      a_d = a_q;
      if (hit_a) begin
        if (ff_q) a_d[WW-1:DW] = wdata_i;
        else      a_d[DW-1:0]  = wdata_i;
      end else if (step) begin
        a_d = a_q + 1'b1;
      end
    end

    always_comb begin
      w_d = w_q;
      if (hit_c) begin
        if (ff_q) w_d[WW-1:DW] = wdata_i;
        else      w_d[DW-1:0]  = wdata_i;
      end else if (step) begin
        w_d = {w_q[WW-1:CW], w_q[CW-1:0] - 1'b1};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
      end else if (a_ld) begin
        a_q <= a_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= '0;
      end else if (w_ld) begin
        w_q <= w_d;
      end
    end

    assign addr_o[k] = a_q;
    assign cnt_o[k]  = w_q[CW-1:0];
    assign typ_o[k]  = w_q[WW-1:WW-2];
  end

  always_comb begin
    ff_d = ff_q;
    if (wr_ok) begin
      if (sel_mode)      ff_d = 1'b0;
      else if (sel_chan) ff_d = !ff_q;
    end
  end

  always_comb begin
    en_d = en_q;
    if (wr_ok && sel_mode) en_d = wdata_i[NCH-1:0];
    if (upd_i && (cnt_o[upd_ch_i] == '0)) en_d[upd_ch_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
      en_q <= '0;
    end else begin
      ff_q <= ff_d;
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

  AST_TC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && (cnt_o[upd_ch_i] == '0)) |=> !en_q[$past(upd_ch_i)]); // R8

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !upd_i) |=> ($stable(addr_o) && $stable(cnt_o) && $stable(typ_o) && $stable(ff_q))); // R11

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o,
  output logic [CHW-1:0] idx_o,
  output logic           any_o
);

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        gnt_o    = '0;
        gnt_o[k] = 1'b1;
        idx_o    = CHW'(k);
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/dma4_xfer.sv
module dma4_xfer
  import dma4_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int AW       = 16,
  parameter int CW       = 14,
  parameter int CHW      = 2,
  parameter int MARK_INT = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pend_i,
  input  logic [CHW-1:0]         win_i,
  input  logic                   hack_i,
  input  logic                   rdy_i,
  input  logic [NCH-1:0][AW-1:0] addr_i,
  input  logic [NCH-1:0][CW-1:0] cnt_i,
  input  logic [NCH-1:0][1:0]    typ_i,
  output logic                   hreq_o,
  output logic                   aen_o,
  output logic                   adstb_o,
  output logic [AW-1:0]          addr_o,
  output logic [NCH-1:0]         dack_n_o,
  output logic                   memr_n_o,
  output logic                   memw_n_o,
  output logic                   ior_n_o,
  output logic                   iow_n_o,
  output logic                   tc_o,
  output logic                   mark_o,
  output logic                   upd_o,
  output logic [CHW-1:0]         upd_ch_o
);

  localparam int MW = (MARK_INT > 1) ? $clog2(MARK_INT) : 1;
  localparam logic [MW-1:0] MLAST = MW'(MARK_INT - 1);

  dma_st_e        st_q, st_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [MW-1:0]  mcnt_q, mcnt_d;
  logic           act, strb;
  logic [1:0]     kind;

  always_comb begin
    st_d = st_q;
    ch_d = ch_q;
    unique case (st_q)
      ST_IDLE: if (pend_i) st_d = ST_WAIT;
      ST_WAIT: if (hack_i) st_d = ST_ARB;
      ST_ARB: begin
        if (pend_i) begin
          st_d = ST_ADDR;
          ch_d = win_i;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_ADDR: st_d = ST_STRB;
      ST_STRB: if (rdy_i) st_d = ST_ARB;
      default: st_d = ST_IDLE;
    endcase
  end

  assign upd_o    = (st_q == ST_STRB) && rdy_i;
  assign upd_ch_o = ch_q;

  always_comb begin
    mcnt_d = mcnt_q;
    if (upd_o) mcnt_d = (mcnt_q == MLAST) ? '0 : mcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ch_q <= '0;
    end else begin
      st_q <= st_d;
      ch_q <= ch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt_q <= '0;
    end else if (upd_o) begin
      mcnt_q <= mcnt_d;
    end
  end

  assign act  = (st_q == ST_ADDR) || (st_q == ST_STRB);
  assign strb = (st_q == ST_STRB);
  assign kind = typ_i[ch_q];

  assign hreq_o   = (st_q != ST_IDLE);
  assign aen_o    = act;
  assign adstb_o  = (st_q == ST_ADDR);
  assign addr_o   = act ? addr_i[ch_q] : '0;
  assign memr_n_o = !(strb && (kind == XK_READ));
  assign iow_n_o  = !(strb && (kind == XK_READ));
  assign ior_n_o  = !(strb && (kind == XK_WRITE));
  assign memw_n_o = !(strb && (kind == XK_WRITE));
  assign tc_o     = strb && (cnt_i[ch_q] == '0);
  assign mark_o   = strb && (mcnt_q == MLAST);

  always_comb begin
    dack_n_o = '1;
    if (act) dack_n_o[ch_q] = 1'b0;
  end

  AST_BUS_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hreq_o) |=> !aen_o); // R3

  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !memr_n_o |-> (!iow_n_o && memw_n_o && ior_n_o)); // R6

  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !memw_n_o |-> (!ior_n_o && memr_n_o && iow_n_o)); // R6

  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !rdy_i) |=> (strb && $stable(addr_o) && $stable(memr_n_o) && $stable(memw_n_o))); // R7

  AST_MARK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    mark_o |-> (aen_o && !adstb_o)); // R9

  AST_TC_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> (dack_n_o != '1)); // R8

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int AW       = 16,
  parameter int CW       = 14,
  parameter int DW       = 8,
  parameter int MARK_INT = 128,
  localparam int RAW     = $clog2(2 * NCH + 1),
  localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic [NCH-1:0] dreq,
  input  logic           hold_ack,
  input  logic           ready,
  output logic           hold_req,
  output logic [NCH-1:0] dack_n,
  output logic           bus_en,
  output logic           addr_stb,
  output logic [AW-1:0]  bus_addr,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           io_rd_n,
  output logic           io_wr_n,
  output logic           term_cnt,
  output logic           mark_pulse
);

  logic [1:0]             rsync_q;
  logic                   rst_n_s;
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][CW-1:0] ch_cnt;
  logic [NCH-1:0][1:0]    ch_typ;
  logic [NCH-1:0]         ch_en;
  logic [NCH-1:0]         pend_vec;
  logic [NCH-1:0]         gnt;
  logic [CHW-1:0]         win;
  logic                   pend_any;
  logic                   upd;
  logic [CHW-1:0]         upd_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  dma4_regs #(
    .NCH(NCH), .AW(AW), .CW(CW), .DW(DW), .RAW(RAW), .CHW(CHW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_i     (reg_wr),
    .waddr_i  (reg_addr),
    .wdata_i  (reg_wdata),
    .lock_i   (hold_req),
    .upd_i    (upd),
    .upd_ch_i (upd_ch),
    .addr_o   (ch_addr),
    .cnt_o    (ch_cnt),
    .typ_o    (ch_typ),
    .en_o     (ch_en)
  );

  assign pend_vec = dreq & ch_en;

  dma4_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .req_i (pend_vec),
    .gnt_o (gnt),
    .idx_o (win),
    .any_o (pend_any)
  );

  dma4_xfer #(
    .NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW), .MARK_INT(MARK_INT)
  ) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pend_i   (pend_any),
    .win_i    (win),
    .hack_i   (hold_ack),
    .rdy_i    (ready),
    .addr_i   (ch_addr),
    .cnt_i    (ch_cnt),
    .typ_i    (ch_typ),
    .hreq_o   (hold_req),
    .aen_o    (bus_en),
    .adstb_o  (addr_stb),
    .addr_o   (bus_addr),
    .dack_n_o (dack_n),
    .memr_n_o (mem_rd_n),
    .memw_n_o (mem_wr_n),
    .ior_n_o  (io_rd_n),
    .iow_n_o  (io_wr_n),
    .tc_o     (term_cnt),
    .mark_o   (mark_pulse),
    .upd_o    (upd),
    .upd_ch_o (upd_ch)
  );

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(~dack_n)); // R5

  AST_DACK_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dack_n != '1) |-> hold_req); // R3

  AST_GNT_PRIO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (gnt != '0) |-> ($onehot0(gnt) && ((gnt & ~pend_vec) == '0) && (((gnt - 1'b1) & pend_vec) == '0))); // R4

endmodule

// File: tb/tb_dma4_ctrl.sv
module tb_dma4_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [3:0]  dreq;
  logic        hold_ack;
  logic        ready;
  logic        hold_req;
  logic [3:0]  dack_n;
  logic        bus_en;
  logic        addr_stb;
  logic [15:0] bus_addr;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic        term_cnt;
  logic        mark_pulse;

  int checks = 0;
  int errors = 0;
  int marks_seen;

  dma4_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dreq(dreq), .hold_ack(hold_ack), .ready(ready),
    .hold_req(hold_req), .dack_n(dack_n), .bus_en(bus_en), .addr_stb(addr_stb),
    .bus_addr(bus_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .term_cnt(term_cnt),
    .mark_pulse(mark_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes_for(input logic [1:0] kind);
    if (kind == 2'b10)      return 4'b0110;
    else if (kind == 2'b01) return 4'b1001;
    else                    return 4'b1111;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dreq = '0; hold_ack = 1'b0; ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic prog_ch(input int ch, input logic [15:0] a, input logic [13:0] c, input logic [1:0] kind);
    wr_reg(4'(2 * ch), a[7:0]);
    wr_reg(4'(2 * ch), a[15:8]);
    wr_reg(4'(2 * ch + 1), c[7:0]);
    wr_reg(4'(2 * ch + 1), {kind, c[13:8]});
  endtask

  task automatic set_mode(input logic [3:0] en);
    wr_reg(4'd8, {4'h0, en});
  endtask

  task automatic wait_adstb(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (addr_stb) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20; i++) begin
      if (!hold_req) break;
      @(negedge clk);
    end
    dreq = '0; hold_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_channel(input int ch, input logic [15:0] a0, input int n,
                             input logic [1:0] kind, input bit chk_mark);
    logic [15:0] ea;
    int idx;
    ea = a0; idx = 0;
    dreq[ch] = 1'b1; hold_ack = 1'b1;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (addr_stb) begin
        chk(bus_addr == ea, "R5 address phase bus_addr", 32'(bus_addr), 32'(ea));
        chk(dack_n == ~(4'b0001 << ch), "R5 dack_n", 32'(dack_n), 32'(~(4'b0001 << ch)));
        @(negedge clk);
        chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == strobes_for(kind), "R6 strobes",
            32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'(strobes_for(kind)));
        chk(term_cnt == (idx == n - 1), "R8 term_cnt", 32'(term_cnt), 32'(idx == n - 1));
        if (chk_mark) begin
          chk(mark_pulse == ((idx % 128) == 127), "R9 mark_pulse", 32'(mark_pulse), 32'((idx % 128) == 127));
          if (mark_pulse) marks_seen++;
        end
        idx++; ea++;
      end else if (!hold_req && idx > 0) begin
        break;
      end
    end
    dreq[ch] = 1'b0; hold_ack = 1'b0;
    chk(idx == n, "R8 transfer count", 32'(idx), 32'(n));
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(hold_req == 1'b0, "R1 hold_req", 32'(hold_req), 0);
    chk(dack_n == 4'hF, "R1 dack_n", 32'(dack_n), 32'hF);
    chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R1 strobes",
        32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'hF);
    chk({bus_en, addr_stb, term_cnt, mark_pulse} == 4'h0, "R1 flags",
        32'({bus_en, addr_stb, term_cnt, mark_pulse}), 0);
    chk(bus_addr == 16'h0, "R1 bus_addr", 32'(bus_addr), 0);
    dreq = 4'hF;
    repeat (4) @(negedge clk);
    chk(hold_req == 1'b0, "R1 channels disabled", 32'(hold_req), 0);
    dreq = '0;
    @(negedge clk);
  endtask

  task automatic t_mark();
    marks_seen = 0;
    prog_ch(0, 16'h0100, 14'd199, 2'b10);
    set_mode(4'b0001);
    run_channel(0, 16'h0100, 200, 2'b10, 1'b1);
    chk(marks_seen == 1, "R9 mark count", 32'(marks_seen), 1);
  endtask

  task automatic t_bytes();
    wr_reg(4'd2, 8'h55);
    set_mode(4'b0000);
    prog_ch(1, 16'h12AB, 14'd2, 2'b10);
    set_mode(4'b0010);
    run_channel(1, 16'h12AB, 3, 2'b10, 1'b0);
    dreq[1] = 1'b1;
    repeat (4) @(negedge clk);
    chk(hold_req == 1'b0, "R8 channel disabled after block", 32'(hold_req), 0);
    dreq = '0;
    @(negedge clk);
  endtask

  task automatic t_hold();
    bit seen;
    prog_ch(0, 16'h3000, 14'd0, 2'b00);
    set_mode(4'b0001);
    dreq[0] = 1'b1; hold_ack = 1'b0;
    @(negedge clk);
    chk(hold_req == 1'b1, "R3 hold_req next clock", 32'(hold_req), 1);
    repeat (3) @(negedge clk);
    chk(bus_en == 1'b0, "R3 bus_en without grant", 32'(bus_en), 0);
    chk(dack_n == 4'hF, "R3 dack_n without grant", 32'(dack_n), 32'hF);
    wr_reg(4'd0, 8'hEE);
    wr_reg(4'd0, 8'hEE);
    hold_ack = 1'b1;
    wait_adstb(seen);
    chk(seen, "R3 transfer after grant", 32'(seen), 1);
    chk(bus_addr == 16'h3000, "R11 locked write ignored", 32'(bus_addr), 32'h3000);
    @(negedge clk);
    chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R6 verify no strobe",
        32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'hF);
    chk(term_cnt == 1'b1, "R8 single transfer tc", 32'(term_cnt), 1);
    @(negedge clk);
    chk(hold_req == 1'b1, "R10 arbitration cycle", 32'(hold_req), 1);
    @(negedge clk);
    chk(hold_req == 1'b0, "R10 hold released", 32'(hold_req), 0);
    dreq = '0; hold_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_priority();
    bit seen;
    prog_ch(2, 16'h2200, 14'd0, 2'b10);
    prog_ch(3, 16'h3300, 14'd0, 2'b10);
    set_mode(4'b1100);
    dreq = 4'b1110; hold_ack = 1'b1;
    wait_adstb(seen);
    chk(bus_addr == 16'h2200, "R4 first winner address", 32'(bus_addr), 32'h2200);
    chk(dack_n == 4'b1011, "R4 first winner dack", 32'(dack_n), 32'hB);
    wait_adstb(seen);
    chk(bus_addr == 16'h3300, "R4 second winner address", 32'(bus_addr), 32'h3300);
    chk(dack_n == 4'b0111, "R4 second winner dack", 32'(dack_n), 32'h7);
    wait_idle();
    chk(hold_req == 1'b0, "R2 disabled channel 1 ignored", 32'(hold_req), 0);
  endtask

  task automatic t_types();
    for (int t = 0; t < 4; t++) begin
      prog_ch(0, 16'(16'h4000 + t * 16), 14'd0, 2'(t));
      set_mode(4'b0001);
      run_channel(0, 16'(16'h4000 + t * 16), 1, 2'(t), 1'b0);
    end
  endtask

  task automatic t_ready();
    bit seen;
    prog_ch(0, 16'h5000, 14'd0, 2'b10);
    set_mode(4'b0001);
    dreq[0] = 1'b1; hold_ack = 1'b1;
    wait_adstb(seen);
    ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(mem_rd_n == 1'b0 && io_wr_n == 1'b0, "R7 strobe held", 32'({mem_rd_n, io_wr_n}), 0);
      chk(bus_addr == 16'h5000, "R7 address held", 32'(bus_addr), 32'h5000);
    end
    ready = 1'b1;
    @(negedge clk);
    chk(mem_rd_n == 1'b1, "R7 strobe ends after ready", 32'(mem_rd_n), 1);
    wait_idle();
  endtask

  initial begin
    do_reset();
    t_reset();
    t_mark();
    t_bytes();
    t_hold();
    t_priority();
    t_types();
    t_ready();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule